// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the command path of an SDRAM controller and turns one read or write column command into the column address for every beat of the burst. A mode word holds the burst length, the wrap order and the CAS latency. The word is written with a load strobe and decoded into a small configuration register. When a column command is accepted, the generator puts out the start column on the next cycle. It then puts out one further column per clock until the burst completes, a burst-stop arrives, or a newer column command takes over. The programmed CAS latency and a mode error flag are presented as plain status outputs for the data-path timing logic, which sits outside this block.

The beat output is a valid-qualified stream with no ready signal. A DRAM column burst cannot be paused from this side, so the consumer must take a beat on every cycle in which `beat_valid` is high. The command input has no ready signal either: a command is accepted on every edge at which `cmd_valid` is high, including in the middle of a burst. Burst length and order are captured with each command, so a mode load never changes a burst that is already running.

Top module: `sbc_colgen`

## Requirements
- R1: A mode load captures the word at the edge where `mode_load` is high. Field positions are: bits [2:0] length code (000=1, 001=2, 010=4, 011=8, 111=full page), bit 3 order (0 sequential, 1 interleaved), bits [6:4] latency code (010 gives `cas_lat`=2, 011 gives `cas_lat`=3). The new settings apply only to commands accepted after that edge; a burst in flight keeps its own length and order.
- R2: A reserved length code (100, 101, 110) acts as length 1 and sets `mode_err`. A reserved latency code sets `cas_lat` to 3 and sets `mode_err`. Any of address bits 7, 8, 11, 12 or either `mode_bank` bit being high sets `mode_err`. `mode_err` is recomputed on every load; bits 9 and 10 alone never set it.
- R3: A command accepted at an edge shows beat 0 (the start column) on the following cycle. Each later edge advances one beat. `beat_valid` stays high for exactly L cycles, `beat_last` marks beat L-1 only, and `beat_valid` falls on the next cycle.
- R4: In sequential order, beat n keeps the start column's bits above log2(L) and replaces the low log2(L) bits with (start + n) mod L.
- R5: In interleaved order, beat n keeps the upper bits and replaces the low log2(L) bits with (start mod L) XOR n.
- R6: A full-page burst gives (start + n) mod 2^COL_W, wrapping around the page. It never raises `beat_last`, runs until stopped or replaced, and ignores the order bit.
- R7: With mode bit 9 high, a write command gives a single beat, while reads keep the programmed length. `beat_write` reports whether the running burst came from a write.
- R8: A `burst_stop` at an edge during a burst, with no command at that edge, makes `beat_valid` low on the next cycle. A stop while idle has no effect.
- R9: A command arriving during a burst abandons the old burst and starts from its own column on the next cycle. It takes priority over a `burst_stop` at the same edge.
- R10: After reset, `beat_valid` and `beat_last` are 0, `cas_lat` is 3, `mode_err` is 0, and the mode is length 1, sequential, with writes at the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load the mode word on this edge |
| mode_addr | input | 13 | Mode word carried on the address lines |
| mode_bank | input | 2 | Bank lines during mode load; must be zero |
| cmd_valid | input | 1 | Column command present |
| cmd_write | input | 1 | Command is a write (1) or a read (0) |
| cmd_col | input | COL_W | Start column of the command |
| burst_stop | input | 1 | Terminate the running burst |
| beat_valid | output | 1 | A beat column is presented this cycle |
| beat_col | output | COL_W | Column for the current beat |
| beat_last | output | 1 | Current beat is the final one of a bounded burst |
| beat_write | output | 1 | Running burst came from a write command |
| cas_lat | output | 2 | Programmed CAS latency in clocks |
| mode_err | output | 1 | Last loaded mode word used a reserved or test setting |

## Verification
The bench sweeps every start column on a 32-column page for each bounded length and both orders. A wrong wrap would show up as a column leaving its aligned block, or, in interleaved order, as a sum where an XOR belongs. A full-page burst is run past the page end, to catch a design that stops at the wrap or raises `beat_last`. Stops are applied mid-burst, while idle, and on the same edge as a new command; a design with the wrong priority would go idle instead of restarting. A single-write mode, reserved length and latency codes, each test bit, and a mode load during a running burst are also covered. These catch a design that stretches write bursts, misses the error flag, or rereads the mode word on every beat.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int MW_W = 13;
  localparam int BA_W = 2;

  typedef enum logic [2:0] {
    LEN_1,
    LEN_2,
    LEN_4,
    LEN_8,
    LEN_PAGE
  } blen_e;

  typedef struct packed {
    blen_e      len;
    logic       intl;
    logic [1:0] cas_lat;
    logic       wr_single;
    logic       err;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RESET = '{len: LEN_1, intl: 1'b0, cas_lat: 2'd3,
                                      wr_single: 1'b0, err: 1'b0};

endpackage

// File: rtl/sbc_mode_reg.sv
module sbc_mode_reg
  import sbc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MW_W-1:0] addr,
  input  logic [BA_W-1:0] bank,
  output mode_cfg_t       cfg
);

  mode_cfg_t dec;
  logic      test_bits;
  logic      unused_a10;

  assign unused_a10 = addr[10];
  assign test_bits  = addr[7] | addr[8] | addr[11] | addr[12] | (|bank);

  always_comb begin
    dec           = CFG_RESET;
    dec.intl      = addr[3];
    dec.wr_single = addr[9];
    dec.err       = test_bits;
    case (addr[2:0])
      3'b000:  dec.len = LEN_1;
      3'b001:  dec.len = LEN_2;
      3'b010:  dec.len = LEN_4;
      3'b011:  dec.len = LEN_8;
      3'b111:  dec.len = LEN_PAGE;
      default: begin
        dec.len = LEN_1;
        dec.err = 1'b1;
      end
    endcase
    case (addr[6:4])
      3'b010:  dec.cas_lat = 2'd2;
      3'b011:  dec.cas_lat = 2'd3;
      default: begin
        dec.cas_lat = 2'd3;
        dec.err     = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cfg <= CFG_RESET;
    else if (load) cfg <= dec;
  end

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cas_lat == 2'd2) || (cfg.cas_lat == 2'd3)); // R1
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg)); // R1
  AST_RSVD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    load && addr[2] && !(addr[1] && addr[0]) |=> cfg.err && (cfg.len == LEN_1)); // R2
  AST_TEST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    load && (addr[7] || addr[12] || bank != '0) |=> cfg.err); // R2

endmodule

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq
  import sbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [CNT_W-1:0] cmd_col,
  input  logic             burst_stop,
  input  mode_cfg_t        cfg,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] mask_q,
  output logic             intl_q,
  output logic             full_q,
  output logic             write_q,
  output logic             last
);

  logic             single_n;
  logic             full_n;
  logic [CNT_W-1:0] mask_n;

  assign single_n = cmd_write && cfg.wr_single;
  assign full_n   = (cfg.len == LEN_PAGE) && !single_n;

  always_comb begin
    if (single_n) mask_n = '0;
    else begin
      case (cfg.len)
        LEN_2:    mask_n = CNT_W'(1);
        LEN_4:    mask_n = CNT_W'(3);
        LEN_8:    mask_n = CNT_W'(7);
        LEN_PAGE: mask_n = '1;
        default:  mask_n = '0;
      endcase
    end
  end

  assign last = active && !full_q && (cnt == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      start_q <= '0;
      mask_q  <= '0;
      intl_q  <= 1'b0;
      full_q  <= 1'b0;
      write_q <= 1'b0;
    end else if (cmd_valid) begin
      active  <= 1'b1;
      cnt     <= '0;
      start_q <= cmd_col;
      mask_q  <= mask_n;
      intl_q  <= cfg.intl && !full_n;
      full_q  <= full_n;
      write_q <= cmd_write;
    end else if (active && (burst_stop || last)) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> active && (cnt == '0) && (start_q == $past(cmd_col))); // R9
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && !last && !burst_stop && !cmd_valid |=> active && (cnt == $past(cnt) + CNT_W'(1))); // R3
  AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    last && !cmd_valid |=> !active); // R3
  AST_STOP_END: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop && !cmd_valid |=> !active); // R8
  AST_SINGLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write && cfg.wr_single |=> last); // R7
  AST_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    active && full_q && !burst_stop |=> active); // R6

endmodule

// File: rtl/sbc_col_map.sv
module sbc_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             intl,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;

  assign sum = start + cnt;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!mask[i])  col[i] = start[i];
      else if (intl) col[i] = start[i] ^ cnt[i];
      else           col[i] = sum[i];
    end
  end

endmodule

// File: rtl/sbc_colgen.sv
module sbc_colgen
  import sbc_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [12:0]      mode_addr,
  input  logic [1:0]       mode_bank,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             burst_stop,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_write,
  output logic [1:0]       cas_lat,
  output logic             mode_err
);

  mode_cfg_t        cfg;
  logic             active;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             intl_q;
  logic             full_q;
  logic             write_q;
  logic             last;

  sbc_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .addr  (mode_addr),
    .bank  (mode_bank),
    .cfg   (cfg)
  );

  sbc_burst_seq #(.CNT_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_write  (cmd_write),
    .cmd_col    (cmd_col),
    .burst_stop (burst_stop),
    .cfg        (cfg),
    .active     (active),
    .cnt        (cnt),
    .start_q    (start_q),
    .mask_q     (mask_q),
    .intl_q     (intl_q),
    .full_q     (full_q),
    .write_q    (write_q),
    .last       (last)
  );

  sbc_col_map #(.COL_W(COL_W)) u_map (
    .start (start_q),
    .cnt   (cnt),
    .mask  (mask_q),
    .intl  (intl_q),
    .col   (beat_col)
  );

  assign beat_valid = active;
  assign beat_last  = last;
  assign beat_write = write_q;
  assign cas_lat    = cfg.cas_lat;
  assign mode_err   = cfg.err;

  AST_BEAT0_COL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid && (beat_col == $past(cmd_col))); // R3
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid); // R3
  AST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (((beat_col ^ start_q) & ~mask_q) == '0)); // R4
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && full_q |-> !beat_last); // R6

endmodule

// File: tb/sim_sbc_colgen.sv
`timescale 1ns/1ps
module sim_sbc_colgen;

  localparam int CW   = 5;
  localparam int PAGE = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_load = 1'b0;
  logic [12:0]   mode_addr = '0;
  logic [1:0]    mode_bank = '0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [CW-1:0] cmd_col = '0;
  logic          burst_stop = 1'b0;
  logic          beat_valid;
  logic [CW-1:0] beat_col;
  logic          beat_last;
  logic          beat_write;
  logic [1:0]    cas_lat;
  logic          mode_err;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  sbc_colgen #(.COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_addr(mode_addr),
    .mode_bank(mode_bank), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .burst_stop(burst_stop), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .beat_write(beat_write),
    .cas_lat(cas_lat), .mode_err(mode_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mw(input int bl, input int bt, input int cl, input int wb);
    return 13'((wb << 9) | (cl << 4) | (bt << 3) | bl);
  endfunction

  function automatic int exp_col(input int s, input int n, input int len, input bit intl);
    int lo;
    if (len == 0) return (s + n) % PAGE;
    lo = s % len;
    return (s - lo) + (intl ? (lo ^ n) : ((lo + n) % len));
  endfunction

  task automatic load_mode(input logic [12:0] a, input logic [1:0] b);
    mode_load = 1'b1; mode_addr = a; mode_bank = b;
    @(negedge clk);
    mode_load = 1'b0; mode_bank = '0;
  endtask

  task automatic issue(input bit wr, input int s);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = CW'(s);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_beat(input string req, input int s, input int n, input int len,
                            input bit intl, input bit wr);
    check(req, "valid", int'(beat_valid), 1);
    check(req, "col", int'(beat_col), exp_col(s, n, len, intl));
    check(req, "last", int'(beat_last), (len != 0 && n == len - 1) ? 1 : 0);
    check(req, "write", int'(beat_write), int'(wr));
  endtask

  task automatic full_burst(input string req, input bit wr, input int s, input int len, input bit intl);
    issue(wr, s);
    for (int n = 0; n < len; n++) begin
      check_beat(req, s, n, len, intl, wr);
      @(negedge clk);
    end
    check(req, "idle after burst", int'(beat_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10", "valid", int'(beat_valid), 0);
    check("R10", "last", int'(beat_last), 0);
    check("R10", "cas_lat", int'(cas_lat), 3);
    check("R10", "mode_err", int'(mode_err), 0);
    full_burst("R10", 1'b1, 11, 1, 1'b0);

    // R3 R4 R5 sweep over length, order and every start column
    for (int code = 0; code < 4; code++) begin
      for (int bt = 0; bt < 2; bt++) begin
        load_mode(mw(code, bt, 2, 0), 2'b00);
        check("R1", "cas_lat", int'(cas_lat), 2);
        check("R1", "mode_err", int'(mode_err), 0);
        for (int s = 0; s < PAGE; s++)
          full_burst(bt ? "R5" : "R4", s[0], s, 1 << code, bt[0]);
      end
    end

    // R1 R2 latency codes
    for (int cl = 0; cl < 8; cl++) begin
      load_mode(mw(0, 0, cl, 0), 2'b00);
      check(cl == 2 || cl == 3 ? "R1" : "R2", "cas_lat", int'(cas_lat), cl == 2 ? 2 : 3);
      check(cl == 2 || cl == 3 ? "R1" : "R2", "mode_err", int'(mode_err), (cl == 2 || cl == 3) ? 0 : 1);
    end

    // R2 reserved length codes act as length 1
    for (int bl = 4; bl < 7; bl++) begin
      load_mode(mw(bl, 0, 3, 0), 2'b00);
      check("R2", "mode_err rsvd len", int'(mode_err), 1);
      full_burst("R2", 1'b0, 6, 1, 1'b0);
    end

    // R2 test bits and bank bits
    for (int b = 0; b < 4; b++) begin
      int bitpos;
      bitpos = (b == 0) ? 7 : (b == 1) ? 8 : (b == 2) ? 11 : 12;
      load_mode(mw(1, 0, 3, 0) | 13'(1 << bitpos), 2'b00);
      check("R2", "mode_err test bit", int'(mode_err), 1);
    end
    load_mode(mw(1, 0, 3, 0), 2'b01);
    check("R2", "mode_err bank0", int'(mode_err), 1);
    load_mode(mw(1, 0, 3, 0), 2'b10);
    check("R2", "mode_err bank1", int'(mode_err), 1);
    load_mode(mw(1, 0, 3, 1) | 13'(1 << 10), 2'b00);
    check("R2", "mode_err bits 9 10", int'(mode_err), 0);

    // R7 single-location write
    load_mode(mw(3, 0, 3, 1), 2'b00);
    full_burst("R7", 1'b1, 13, 1, 1'b0);
    full_burst("R7", 1'b0, 13, 8, 1'b0);

    // R6 full page past the wrap, order bit set, then stopped
    load_mode(mw(7, 1, 3, 0), 2'b00);
    issue(1'b0, 7);
    for (int n = 0; n < 40; n++) begin
      check_beat("R6", 7, n, 0, 1'b0, 1'b0);
      if (n == 39) burst_stop = 1'b1;
      @(negedge clk);
    end
    burst_stop = 1'b0;
    check("R8", "idle after page stop", int'(beat_valid), 0);

    // R8 stop mid burst
    load_mode(mw(3, 0, 3, 0), 2'b00);
    issue(1'b0, 5);
    for (int n = 0; n < 3; n++) begin
      check_beat("R8", 5, n, 8, 1'b0, 1'b0);
      if (n == 2) burst_stop = 1'b1;
      @(negedge clk);
    end
    burst_stop = 1'b0;
    check("R8", "idle after stop", int'(beat_valid), 0);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check("R8", "stop while idle", int'(beat_valid), 0);
    full_burst("R8", 1'b0, 20, 8, 1'b0);

    // R9 new command interrupts a burst
    issue(1'b0, 2);
    for (int n = 0; n < 3; n++) begin
      check_beat("R9", 2, n, 8, 1'b0, 1'b0);
      if (n < 2) @(negedge clk);
    end
    full_burst("R9", 1'b1, 17, 8, 1'b0);
    issue(1'b0, 3);
    check_beat("R9", 3, 0, 8, 1'b0, 1'b0);
    burst_stop = 1'b1;
    issue(1'b0, 9);
    burst_stop = 1'b0;
    check_beat("R9", 9, 0, 8, 1'b0, 1'b0);
    for (int n = 1; n < 8; n++) begin
      @(negedge clk);
      check_beat("R9", 9, n, 8, 1'b0, 1'b0);
    end
    @(negedge clk);
    check("R9", "idle", int'(beat_valid), 0);

    // R1 mode load during a running burst keeps the old settings
    load_mode(mw(2, 0, 3, 0), 2'b00);
    issue(1'b0, 6);
    check_beat("R1", 6, 0, 4, 1'b0, 1'b0);
    load_mode(mw(3, 1, 2, 0), 2'b00);
    for (int n = 1; n < 4; n++) begin
      check_beat("R1", 6, n, 4, 1'b0, 1'b0);
      @(negedge clk);
    end
    check("R1", "idle after old burst", int'(beat_valid), 0);
    full_burst("R1", 1'b0, 6, 8, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule